// File: doc/BRIEF.md
# Two-Channel Pointer-Addressed Register File

This block is the register interface of a two-channel serial controller. Each channel has a control port and a data port. Control-port access works in two stages. A write made while the channel's pointer is zero loads the pointer and can also issue a command. The next control access, read or write, goes to the register the pointer selects. The pointer then falls back to zero. The data port reaches the transmit and receive data path directly and never touches the pointer.

The block keeps the writable control registers of each channel and one master register shared by both channels. It turns command-only fields into one-cycle pulses. It banks register 7 behind a select bit in register 15. It mirrors write registers onto read addresses when an extended-read bit is set. It also applies the read rules that depend on the channel. The serial engines are outside the block: live status arrives on inputs, and transmit loads, commands, reset requests and PLL commands leave as registered pulses. Read data appears on `rd_data_o` one clock after the access, qualified by `rd_valid_o`. Channel 0 is channel A and channel 1 is channel B.

Top module: `scc_regfile`

## Requirements
- R1: A synchronous active-high reset clears both pointers, every stored register and the shared register, and zeroes all outputs. A read of register 12 right after reset returns 0x00.
- R2: A control write with the channel pointer at zero loads the pointer from data bits 3:0. If data bits 7:4 are nonzero, the next cycle carries a one-cycle `cmd_valid_o` with `cmd_code_o` equal to bits 7:4 and `cmd_chan_o` equal to the channel.
- R3: A control access made while the pointer is nonzero reads or writes the selected register, and the pointer then returns to zero. A further control read therefore returns register 0.
- R4: A data-port write raises `tx_load_o` for one cycle, with the data and the channel. A data-port read returns that channel's `rx_data_i` byte. Neither changes the pointer.
- R5: A control write to register 8 also raises `tx_load_o`, with the written byte and the channel.
- R6: Register 9 is a single register shared by both channels, and bits 5:0 of a write are kept on `shared_cfg_o`. Bits 7:6 are not stored. Their code (01 reset B, 10 reset A, 11 hard reset) appears for one cycle on `rst_req_o`.
- R7: For a register 14 write, only bits 4:0 are stored. Nonzero bits 7:5 appear for one cycle on `pll_cmd_o`, with `pll_chan_o`.
- R8: A write to register 7 goes to the option register when bit 0 of that channel's register 15 is 1, and to the sync register when it is 0. Neither target overwrites the other.
- R9: When bit 6 of a channel's option register is 1, read addresses 4, 5, 9 and 11 return write registers 4, 5, 3 and 10. When it is 0, those addresses read 0x00.
- R10: Read addresses 12, 13 and 15 always return the channel's write registers 12, 13 and 15.
- R11: Read address 3 on channel A returns {2'b00, `irq_pend_i`}, where bits 2:0 are ext/status, tx and rx for channel B and bits 5:3 are the same three for channel A. On channel B it reads 0x00.
- R12: Read address 2 on channel A returns write register 2 as written. On channel B it returns B's write register 2 with bits 3:1 replaced by `vec_stat_i`.
- R13: Read address 0 returns that channel's `stat_i` byte, 1 returns `spc_i` and 8 returns `rx_data_i`. Addresses 6, 7, 10 and 14 read 0x00. `rd_valid_o` is high only in the cycle after a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Access strobe, one cycle per access |
| acc_write_i | input | 1 | 1 for write, 0 for read |
| acc_dport_i | input | 1 | 1 selects the data port, 0 the control port |
| acc_chan_i | input | 1 | Channel, 0 = A, 1 = B |
| acc_wdata_i | input | 8 | Write data |
| stat_i | input | 16 | Live status, channel A in bits 7:0, channel B in bits 15:8 |
| spc_i | input | 16 | Special-condition status per channel, same layout |
| rx_data_i | input | 16 | Received byte per channel, same layout |
| irq_pend_i | input | 6 | Pending interrupt sources |
| vec_stat_i | input | 3 | Status code merged into channel B's vector read |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |
| tx_load_o | output | 1 | Transmit byte load pulse |
| tx_data_o | output | 8 | Transmit byte |
| tx_chan_o | output | 1 | Transmit channel |
| cmd_valid_o | output | 1 | Command pulse |
| cmd_code_o | output | 4 | Command code |
| cmd_chan_o | output | 1 | Command channel |
| rst_req_o | output | 2 | Reset request code pulse |
| pll_cmd_o | output | 3 | PLL command pulse |
| pll_chan_o | output | 1 | PLL command channel |
| shared_cfg_o | output | 8 | Stored bits of the shared master register |

## Verification
Directed sequences run the two-stage access pattern several ways: pointer-then-write, pointer-then-read, a bare read at pointer zero, and data-port accesses placed between a pointer load and its use. These show whether the pointer clears after a read as well as after a write, and whether the data port leaves the pointer alone. The same register numbers are accessed on both channels. This separates per-channel storage from the shared register, and separates the channel-dependent vector and interrupt-pending reads. Register 7 is written with the bank bit at each value, and the extended-read bit is toggled afterwards. This shows which storage each write reached. A behavioural model in the bench predicts every output in every cycle.

// File: rtl/scc_regs_pkg.sv
package scc_regs_pkg;
  localparam int DW   = 8;
  localparam int NREG = 16;
  localparam int PW   = 4;
  localparam int NCH  = 2;

  localparam logic [3:0] RA_STAT  = 4'd0;
  localparam logic [3:0] RA_SPC   = 4'd1;
  localparam logic [3:0] RA_VEC   = 4'd2;
  localparam logic [3:0] RA_IRQ   = 4'd3;
  localparam logic [3:0] RA_M4    = 4'd4;
  localparam logic [3:0] RA_M5    = 4'd5;
  localparam logic [3:0] RA_SYNC  = 4'd7;
  localparam logic [3:0] RA_DATA  = 4'd8;
  localparam logic [3:0] RA_MSTR  = 4'd9;
  localparam logic [3:0] RA_M11   = 4'd11;
  localparam logic [3:0] RA_T12   = 4'd12;
  localparam logic [3:0] RA_T13   = 4'd13;
  localparam logic [3:0] RA_PLL   = 4'd14;
  localparam logic [3:0] RA_XCTL  = 4'd15;

  localparam logic [3:0] WA_RXC   = 4'd3;
  localparam logic [3:0] WA_AUX   = 4'd10;
  // storage slot of the option register (write address 8 is never stored)
  localparam logic [3:0] ALT_SLOT = 4'd8;

  localparam int BANK_BIT = 0;
  localparam int EXT_BIT  = 6;

  localparam logic [7:0] PLL_KEEP  = 8'h1F;
  localparam logic [7:0] MSTR_KEEP = 8'h3F;
endpackage

// File: rtl/scc_ptr_ctrl.sv
module scc_ptr_ctrl #(
  parameter int NCH = 2,
  parameter int PW  = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    acc_valid_i,
  input  logic                    acc_write_i,
  input  logic                    acc_dport_i,
  input  logic [CW-1:0]           acc_chan_i,
  input  logic [PW-1:0]           wdata_lo_i,
  output logic [NCH-1:0][PW-1:0]  ptr_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = acc_valid_i && !acc_dport_i && (acc_chan_i == CW'(c));
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        ptr_o[c] <= '0;
      end else if (hit) begin
        if (acc_write_i && (ptr_o[c] == '0)) ptr_o[c] <= wdata_lo_i;
        else                                 ptr_o[c] <= '0;
      end
    end
  end
endmodule

// File: rtl/scc_wreg_bank.sv
module scc_wreg_bank #(
  parameter int NCH  = 2,
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG),
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               we_i,
  input  logic [CW-1:0]                      ch_i,
  input  logic [AW-1:0]                      addr_i,
  input  logic [DW-1:0]                      wdata_i,
  output logic [NCH-1:0][NREG-1:0][DW-1:0]   regs_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_bank
    always_ff @(posedge clk_i) begin
      if (rst_i)                          regs_o[c] <= '0;
      else if (we_i && ch_i == CW'(c))    regs_o[c][addr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/scc_read_mux.sv
module scc_read_mux
  import scc_regs_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int NREG  = 16,
  parameter int DW    = 8,
  parameter int NIRQ  = 6,
  parameter int NVEC  = 3,
  localparam int AW   = $clog2(NREG),
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [CW-1:0]                     ch_i,
  input  logic [AW-1:0]                     ptr_i,
  input  logic                              dport_i,
  input  logic [NCH-1:0][NREG-1:0][DW-1:0]  regs_i,
  input  logic [NCH*DW-1:0]                 stat_i,
  input  logic [NCH*DW-1:0]                 spc_i,
  input  logic [NCH*DW-1:0]                 rx_i,
  input  logic [NIRQ-1:0]                   irq_i,
  input  logic [NVEC-1:0]                   vec_i,
  output logic [DW-1:0]                     rdata_o
);
  logic [NREG-1:0][DW-1:0] cur;
  logic                    ext;
  logic [DW-1:0]           stat_b, spc_b, rx_b;

  always_comb begin
    cur    = regs_i[ch_i];
    ext    = cur[ALT_SLOT][EXT_BIT];
    stat_b = stat_i[int'(ch_i)*DW +: DW];
    spc_b  = spc_i[int'(ch_i)*DW +: DW];
    rx_b   = rx_i[int'(ch_i)*DW +: DW];
    rdata_o = '0;
    if (dport_i) begin
      rdata_o = rx_b;
    end else begin
      case (ptr_i)
        RA_STAT: rdata_o = stat_b;
        RA_SPC:  rdata_o = spc_b;
        RA_VEC:  rdata_o = (ch_i == '0) ? cur[RA_VEC]
                         : {cur[RA_VEC][DW-1:NVEC+1], vec_i, cur[RA_VEC][0]};
        RA_IRQ:  rdata_o = (ch_i == '0) ? DW'(irq_i) : '0;
        RA_M4:   rdata_o = ext ? cur[RA_M4] : '0;
        RA_M5:   rdata_o = ext ? cur[RA_M5] : '0;
        RA_DATA: rdata_o = rx_b;
        RA_MSTR: rdata_o = ext ? cur[WA_RXC] : '0;
        RA_M11:  rdata_o = ext ? cur[WA_AUX] : '0;
        RA_T12, RA_T13, RA_XCTL: rdata_o = cur[ptr_i];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/scc_regfile.sv
module scc_regfile
  import scc_regs_pkg::*;
#(
  parameter int NCH  = scc_regs_pkg::NCH,
  parameter int NREG = scc_regs_pkg::NREG,
  parameter int DW   = scc_regs_pkg::DW,
  parameter int NIRQ = 6,
  parameter int NVEC = 3,
  localparam int PW  = $clog2(NREG),
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               acc_valid_i,
  input  logic               acc_write_i,
  input  logic               acc_dport_i,
  input  logic [CW-1:0]      acc_chan_i,
  input  logic [DW-1:0]      acc_wdata_i,
  input  logic [NCH*DW-1:0]  stat_i,
  input  logic [NCH*DW-1:0]  spc_i,
  input  logic [NCH*DW-1:0]  rx_data_i,
  input  logic [NIRQ-1:0]    irq_pend_i,
  input  logic [NVEC-1:0]    vec_stat_i,
  output logic               rd_valid_o,
  output logic [DW-1:0]      rd_data_o,
  output logic               tx_load_o,
  output logic [DW-1:0]      tx_data_o,
  output logic [CW-1:0]      tx_chan_o,
  output logic               cmd_valid_o,
  output logic [3:0]         cmd_code_o,
  output logic [CW-1:0]      cmd_chan_o,
  output logic [1:0]         rst_req_o,
  output logic [2:0]         pll_cmd_o,
  output logic [CW-1:0]      pll_chan_o,
  output logic [DW-1:0]      shared_cfg_o
);
  logic [NCH-1:0][PW-1:0]           ptr_q;
  logic [NCH-1:0][NREG-1:0][DW-1:0] regs;
  logic [PW-1:0]                    cur_ptr;
  logic                             ctl_wr, ctl_rd, ptr_load, reg_wr;
  logic                             bank_we, do_tx, do_mstr, do_pll;
  logic [PW-1:0]                    bank_addr;
  logic [DW-1:0]                    bank_data, rd_next;

  scc_ptr_ctrl #(.NCH(NCH), .PW(PW)) u_ptr (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_dport_i (acc_dport_i),
    .acc_chan_i  (acc_chan_i),
    .wdata_lo_i  (acc_wdata_i[PW-1:0]),
    .ptr_o       (ptr_q)
  );

  always_comb begin
    cur_ptr  = ptr_q[acc_chan_i];
    ctl_wr   = acc_valid_i && !acc_dport_i && acc_write_i;
    ctl_rd   = acc_valid_i && !acc_dport_i && !acc_write_i;
    ptr_load = ctl_wr && (cur_ptr == '0);
    reg_wr   = ctl_wr && (cur_ptr != '0);
    do_tx    = (acc_valid_i && acc_dport_i && acc_write_i) || (reg_wr && cur_ptr == RA_DATA);
    do_mstr  = reg_wr && (cur_ptr == RA_MSTR);
    do_pll   = reg_wr && (cur_ptr == RA_PLL);
    bank_we  = reg_wr && (cur_ptr != RA_DATA) && (cur_ptr != RA_MSTR);
    bank_addr = cur_ptr;
    if (cur_ptr == RA_SYNC && regs[acc_chan_i][RA_XCTL][BANK_BIT]) bank_addr = ALT_SLOT;
    bank_data = do_pll ? (acc_wdata_i & PLL_KEEP) : acc_wdata_i;
  end

  scc_wreg_bank #(.NCH(NCH), .NREG(NREG), .DW(DW)) u_bank (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (bank_we),
    .ch_i    (acc_chan_i),
    .addr_i  (bank_addr),
    .wdata_i (bank_data),
    .regs_o  (regs)
  );

  scc_read_mux #(.NCH(NCH), .NREG(NREG), .DW(DW), .NIRQ(NIRQ), .NVEC(NVEC)) u_rmux (
    .ch_i    (acc_chan_i),
    .ptr_i   (cur_ptr),
    .dport_i (acc_dport_i),
    .regs_i  (regs),
    .stat_i  (stat_i),
    .spc_i   (spc_i),
    .rx_i    (rx_data_i),
    .irq_i   (irq_pend_i),
    .vec_i   (vec_stat_i),
    .rdata_o (rd_next)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      tx_load_o    <= 1'b0;
      tx_data_o    <= '0;
      tx_chan_o    <= '0;
      cmd_valid_o  <= 1'b0;
      cmd_code_o   <= '0;
      cmd_chan_o   <= '0;
      rst_req_o    <= '0;
      pll_cmd_o    <= '0;
      pll_chan_o   <= '0;
      shared_cfg_o <= '0;
    end else begin
      rd_valid_o  <= acc_valid_i && !acc_write_i;
      rd_data_o   <= (acc_valid_i && !acc_write_i) ? rd_next : '0;
      tx_load_o   <= do_tx;
      tx_data_o   <= do_tx ? acc_wdata_i : '0;
      tx_chan_o   <= do_tx ? acc_chan_i : '0;
      cmd_valid_o <= ptr_load && (acc_wdata_i[7:4] != 4'h0);
      cmd_code_o  <= ptr_load ? acc_wdata_i[7:4] : 4'h0;
      cmd_chan_o  <= (ptr_load && acc_wdata_i[7:4] != 4'h0) ? acc_chan_i : '0;
      rst_req_o   <= do_mstr ? acc_wdata_i[7:6] : 2'b00;
      pll_cmd_o   <= do_pll ? acc_wdata_i[7:5] : 3'b000;
      pll_chan_o  <= (do_pll && acc_wdata_i[7:5] != 3'b000) ? acc_chan_i : '0;
      if (do_mstr) shared_cfg_o <= acc_wdata_i & MSTR_KEEP;
    end
  end

  logic unused_rd;
  assign unused_rd = ctl_rd;
endmodule

// File: rtl/scc_regfile_chk.sv
module scc_regfile_chk (
  input logic            clk_i,
  input logic            rst_i,
  input logic            acc_valid_i,
  input logic            acc_write_i,
  input logic            acc_dport_i,
  input logic            acc_chan_i,
  input logic [7:0]      acc_wdata_i,
  input logic [1:0][3:0] ptr_q,
  input logic            rd_valid_o,
  input logic [7:0]      rd_data_o,
  input logic            cmd_valid_o,
  input logic [1:0]      rst_req_o,
  input logic [2:0]      pll_cmd_o
);
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!rd_valid_o && rst_req_o == 2'b00 && ptr_q == '0));

  a_r3_ptr_back_a: assert property (@(posedge clk_i) disable iff (rst_i)
    (acc_valid_i && !acc_dport_i && !acc_chan_i && ptr_q[0] != 4'd0) |=> ptr_q[0] == 4'd0);

  a_r3_ptr_back_b: assert property (@(posedge clk_i) disable iff (rst_i)
    (acc_valid_i && !acc_dport_i && acc_chan_i && ptr_q[1] != 4'd0) |=> ptr_q[1] == 4'd0);

  a_r4_dport_keeps_ptr: assert property (@(posedge clk_i) disable iff (rst_i)
    (acc_valid_i && acc_dport_i) |=> $stable(ptr_q));

  a_r13_rd_valid_src: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_valid_o |-> $past(acc_valid_i && !acc_write_i));

  a_r11_irq_b_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (acc_valid_i && !acc_dport_i && !acc_write_i && acc_chan_i && ptr_q[1] == 4'd3)
      |=> rd_data_o == 8'h00);

  a_r7_pll_src: assert property (@(posedge clk_i) disable iff (rst_i)
    (pll_cmd_o != 3'b000) |-> $past(acc_valid_i && acc_write_i && !acc_dport_i
                                    && acc_wdata_i[7:5] != 3'b000));

  a_r6_rst_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    (rst_req_o != 2'b00) |=> rst_req_o == 2'b00);

  a_r2_cmd_from_ptr0: assert property (@(posedge clk_i) disable iff (rst_i)
    cmd_valid_o |-> $past(acc_valid_i && acc_write_i && !acc_dport_i
                          && ptr_q[acc_chan_i] == 4'd0));
endmodule

bind scc_regfile scc_regfile_chk u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_dport_i (acc_dport_i),
  .acc_chan_i  (acc_chan_i),
  .acc_wdata_i (acc_wdata_i),
  .ptr_q       (ptr_q),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .cmd_valid_o (cmd_valid_o),
  .rst_req_o   (rst_req_o),
  .pll_cmd_o   (pll_cmd_o)
);

// File: tb/tb_scc_regfile.sv
module tb_scc_regfile;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_write = 0, acc_dport = 0, acc_chan = 0;
  logic [7:0]  acc_wdata = 0;
  logic [15:0] stat = 16'hB4A1, spc = 16'h5C3D, rxd = 16'h9E17;
  logic [5:0]  irq = 6'b101101;
  logic [2:0]  vec = 3'b101;

  logic       rd_valid, tx_load, tx_chan, cmd_valid, cmd_chan, pll_chan;
  logic [7:0] rd_data, tx_data, shared_cfg;
  logic [3:0] cmd_code;
  logic [1:0] rst_req;
  logic [2:0] pll_cmd;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scc_regfile dut (
    .clk_i(clk), .rst_i(rst), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_dport_i(acc_dport), .acc_chan_i(acc_chan), .acc_wdata_i(acc_wdata),
    .stat_i(stat), .spc_i(spc), .rx_data_i(rxd), .irq_pend_i(irq), .vec_stat_i(vec),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .tx_load_o(tx_load), .tx_data_o(tx_data),
    .tx_chan_o(tx_chan), .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code),
    .cmd_chan_o(cmd_chan), .rst_req_o(rst_req), .pll_cmd_o(pll_cmd),
    .pll_chan_o(pll_chan), .shared_cfg_o(shared_cfg)
  );

  // behavioural reference model
  logic [7:0] m_wr [2][16];
  logic [7:0] m_alt [2];
  logic [7:0] m_sh;
  int         m_ptr [2];
  logic       e_rdv, e_tx, e_txc, e_cmdv, e_cmdc, e_pllc;
  logic [7:0] e_rd, e_txd, e_sh;
  logic [3:0] e_cmd;
  logic [1:0] e_rst;
  logic [2:0] e_pll;

  function automatic logic [7:0] m_read(input int ch, input int p);
    logic ext;
    ext = m_alt[ch][6];
    case (p)
      0: return stat[ch*8 +: 8];
      1: return spc[ch*8 +: 8];
      2: return (ch == 0) ? m_wr[0][2] : {m_wr[1][2][7:4], vec, m_wr[1][2][0]};
      3: return (ch == 0) ? {2'b00, irq} : 8'h00;
      4: return ext ? m_wr[ch][4] : 8'h00;
      5: return ext ? m_wr[ch][5] : 8'h00;
      8: return rxd[ch*8 +: 8];
      9: return ext ? m_wr[ch][3] : 8'h00;
      11: return ext ? m_wr[ch][10] : 8'h00;
      12, 13, 15: return m_wr[ch][p];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    int c, p;
    e_rdv = 0; e_rd = 0; e_tx = 0; e_txd = 0; e_txc = 0; e_cmdv = 0; e_cmd = 0;
    e_cmdc = 0; e_rst = 0; e_pll = 0; e_pllc = 0;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_ptr[i] = 0; m_alt[i] = 0;
        for (int j = 0; j < 16; j++) m_wr[i][j] = 0;
      end
      m_sh = 0;
    end else if (acc_valid) begin
      c = int'(acc_chan);
      if (acc_dport) begin
        if (acc_write) begin e_tx = 1; e_txd = acc_wdata; e_txc = acc_chan; end
        else begin e_rdv = 1; e_rd = rxd[c*8 +: 8]; end
      end else begin
        p = m_ptr[c];
        if (!acc_write) begin
          e_rdv = 1; e_rd = m_read(c, p); m_ptr[c] = 0;
        end else if (p == 0) begin
          m_ptr[c] = int'(acc_wdata[3:0]);
          e_cmd = acc_wdata[7:4];
          if (acc_wdata[7:4] != 0) begin e_cmdv = 1; e_cmdc = acc_chan; end
        end else begin
          m_ptr[c] = 0;
          if (p == 7) begin
            if (m_wr[c][15][0]) m_alt[c] = acc_wdata; else m_wr[c][7] = acc_wdata;
          end else if (p == 8) begin
            e_tx = 1; e_txd = acc_wdata; e_txc = acc_chan;
          end else if (p == 9) begin
            m_sh = acc_wdata & 8'h3F; e_rst = acc_wdata[7:6];
          end else if (p == 14) begin
            m_wr[c][14] = acc_wdata & 8'h1F; e_pll = acc_wdata[7:5];
            if (acc_wdata[7:5] != 0) e_pllc = acc_chan;
          end else m_wr[c][p] = acc_wdata;
        end
      end
    end
    e_sh = m_sh;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (skip the first edge before the model runs)
  int ncyc = 0;
  always @(negedge clk) begin
    ncyc++;
    if (ncyc > 1) begin
      chk("R13 model rd_valid", 32'(rd_valid), 32'(e_rdv));
      chk("R13 model rd_data", 32'(rd_data), 32'(e_rd));
      chk("R4 model tx", {tx_load, tx_chan, tx_data}, {e_tx, e_txc, e_txd});
      chk("R2 model cmd", {cmd_valid, cmd_chan, cmd_code}, {e_cmdv, e_cmdc, e_cmd});
      chk("R6 model rst_req/shared", {rst_req, shared_cfg}, {e_rst, e_sh});
      chk("R7 model pll", {pll_cmd, pll_chan}, {e_pll, e_pllc});
    end
  end

  task automatic acc(input logic ch, input logic dp, input logic wr, input logic [7:0] d);
    acc_valid = 1; acc_chan = ch; acc_dport = dp; acc_write = wr; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_dport = 0; acc_wdata = 0;
  endtask

  task automatic wreg(input logic ch, input logic [3:0] r, input logic [7:0] d);
    acc(ch, 0, 1, {4'h0, r});
    acc(ch, 0, 1, d);
  endtask

  task automatic rreg(input logic ch, input logic [3:0] r);
    if (r != 0) acc(ch, 0, 1, {4'h0, r});
    acc(ch, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_valid after reset", 32'(rd_valid), 0);
    chk("R1 shared after reset", 32'(shared_cfg), 0);
    rst = 0;
    @(negedge clk);
    rreg(0, 4'd12); chk("R1 WR12 cleared", 32'(rd_data), 32'h00);
    rreg(0, 4'd0);  chk("R13 RR0 live status A", 32'(rd_data), 32'hA1);
    chk("R13 rd_valid on read", 32'(rd_valid), 1);
    rreg(1, 4'd0);  chk("R13 RR0 live status B", 32'(rd_data), 32'hB4);
    rreg(1, 4'd1);  chk("R13 RR1 special status B", 32'(rd_data), 32'h5C);
    rreg(0, 4'd8);  chk("R13 RR8 rx A", 32'(rd_data), 32'h17);

    wreg(0, 4'd12, 8'h5A);
    chk("R13 rd_valid low after write", 32'(rd_valid), 0);
    rreg(0, 4'd12); chk("R10 RR12 alias", 32'(rd_data), 32'h5A);
    acc(0, 0, 1, 8'h0D); acc(0, 0, 0, 8'h00);
    chk("R10 RR13 alias default", 32'(rd_data), 32'h00);
    acc(0, 0, 0, 8'h00); chk("R3 pointer back to 0 after read", 32'(rd_data), 32'hA1);

    acc(0, 0, 1, 8'h30);
    chk("R2 cmd pulse", {cmd_valid, cmd_chan, cmd_code}, {1'b1, 1'b0, 4'h3});
    acc(0, 0, 0, 8'h00); chk("R2 ptr stays 0 with low nibble 0", 32'(rd_data), 32'hA1);
    acc(1, 0, 1, 8'h52);
    chk("R2 cmd pulse B", {cmd_valid, cmd_chan, cmd_code}, {1'b1, 1'b1, 4'h5});
    acc(1, 0, 1, 8'hF0);
    chk("R2 cmd pulse one cycle", 32'(cmd_valid), 0);
    wreg(0, 4'd2, 8'h77);
    rreg(0, 4'd2); chk("R12 vector A as written", 32'(rd_data), 32'h77);
    rreg(1, 4'd2); chk("R12 vector B with status", 32'(rd_data), 32'hFA);

    wreg(0, 4'd9, 8'hC5);
    chk("R6 hard reset request", 32'(rst_req), 32'h3);
    chk("R6 shared keeps low bits", 32'(shared_cfg), 32'h05);
    wreg(1, 4'd9, 8'h4A);
    chk("R6 reset B request", 32'(rst_req), 32'h1);
    chk("R6 shared written from B", 32'(shared_cfg), 32'h0A);
    wreg(0, 4'd9, 8'h80);
    chk("R6 reset A request", 32'(rst_req), 32'h2);

    wreg(1, 4'd14, 8'hE3);
    chk("R7 pll pulse", {pll_cmd, pll_chan}, {3'b111, 1'b1});
    @(negedge clk);
    chk("R7 pll pulse one cycle", 32'(pll_cmd), 0);

    wreg(0, 4'd15, 8'h01);
    rreg(0, 4'd15); chk("R10 RR15 alias", 32'(rd_data), 32'h01);
    wreg(0, 4'd7, 8'h40);
    wreg(0, 4'd4, 8'h11); wreg(0, 4'd5, 8'h22); wreg(0, 4'd3, 8'h33); wreg(0, 4'd10, 8'h44);
    rreg(0, 4'd4);  chk("R9 RR4 mirror", 32'(rd_data), 32'h11);
    rreg(0, 4'd5);  chk("R9 RR5 mirror", 32'(rd_data), 32'h22);
    rreg(0, 4'd9);  chk("R9 RR9 mirrors WR3", 32'(rd_data), 32'h33);
    rreg(0, 4'd11); chk("R9 RR11 mirrors WR10", 32'(rd_data), 32'h44);
    rreg(0, 4'd10); chk("R13 RR10 reads zero", 32'(rd_data), 32'h00);
    wreg(0, 4'd15, 8'h00);
    wreg(0, 4'd7, 8'h99);
    rreg(0, 4'd4);  chk("R8 sync write spares option reg", 32'(rd_data), 32'h11);
    rreg(0, 4'd7);  chk("R13 RR7 reads zero", 32'(rd_data), 32'h00);
    wreg(0, 4'd15, 8'h01);
    wreg(0, 4'd7, 8'h00);
    rreg(0, 4'd4);  chk("R8 option write cleared ext", 32'(rd_data), 32'h00);
    wreg(1, 4'd4, 8'h66);
    rreg(1, 4'd4);  chk("R9 no mirror on B without ext", 32'(rd_data), 32'h00);

    rreg(0, 4'd3);  chk("R11 RR3 on A", 32'(rd_data), 32'h2D);
    rreg(1, 4'd3);  chk("R11 RR3 on B zero", 32'(rd_data), 32'h00);

    acc(0, 1, 1, 8'hA5);
    chk("R4 data port tx", {tx_load, tx_chan, tx_data}, {1'b1, 1'b0, 8'hA5});
    acc(0, 0, 1, 8'h0C);
    acc(1, 1, 0, 8'h00); chk("R4 data port read rx B", 32'(rd_data), 32'h9E);
    acc(0, 1, 0, 8'h00); chk("R4 data port read rx A", 32'(rd_data), 32'h17);
    acc(0, 0, 0, 8'h00); chk("R4 pointer kept across data port", 32'(rd_data), 32'h5A);
    wreg(1, 4'd8, 8'h3C);
    chk("R5 ctrl tx load", {tx_load, tx_chan, tx_data}, {1'b1, 1'b1, 8'h3C});

    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    rreg(0, 4'd12); chk("R1 WR12 cleared by reset", 32'(rd_data), 32'h00);
    chk("R1 shared cleared by reset", 32'(shared_cfg), 32'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule